// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Gate

This block is the card-side interrupt logic for a two-channel IDE interface sitting on a byte-wide memory-mapped bus. Each channel has its own gate. Any bus write to the channel's control location opens the gate, and any bus read of that location closes it. The data byte plays no part. The IRQ line from each drive is registered every clock. Bit 0 of the channel's status location reports the registered level. One shared interrupt output is raised whenever an open channel has its IRQ registered high.

Host software picks the active channel by writing that channel's control location and reading the other one. It parks the card in a safe state by reading both. The block also holds a small select register. One bit of it opens the extended register window and another routes DMA to one of the two channels. A fixed four-bit card code can be read back one bit per location, through bit 0 of four locations spaced four bytes apart.

Read data is registered. It appears on the cycle after the read strobe and is 0x00 at all other times.

Top module: `ide_irq_gate`

## Requirements
- R1: A write strobe to a channel's control location (channel 0 at 0x2200, channel 1 at 0x3200) enables that channel's interrupt for any data byte, including 0x00 and 0xFF.
- R2: A read strobe to a channel's control location disables that channel's interrupt, and the read returns 0x00.
- R3: Reading a channel's status location (channel 0 at 0x2290, channel 1 at 0x3290) returns the registered drive IRQ level in bit 0 and zeros in bits 7..1, whether or not the channel is enabled.
- R4: irq_out is high exactly when some channel is enabled and its registered IRQ is high. A change on a drive IRQ line reaches irq_out on the second rising clock edge after it.
- R5: Each channel's enable is independent. Writing one control location and reading the other leaves only the first channel enabled, and the mirror sequence leaves only the other channel enabled.
- R6: Bit 0 of the byte read at 0x2280 + 4*i gives bit i of the card code, for i = 0..3. The default code is 3, so the four reads return 1, 1, 0, 0 and every other bit reads 0.
- R7: A write to offset 0 loads the select register. Data bit 5 drives win_en and data bit 0 drives dma_ch_sel, and a read of offset 0 returns the held byte with only bits 5 and 0 possibly set. Writing 0x00 clears both.
- R8: After reset, both channel enables are cleared, the select register is 0, and irq_out is 0, even while drive IRQ lines are high.
- R9: Reads of any other offset return 0x00. Writes to status, identity or unmapped offsets change no enable and no select bit.
- R10: If a read strobe and a write strobe hit a control location in the same cycle, the read wins and the channel ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (14) | Byte offset of the bus access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd, else 0x00 |
| drv_irq | input | NUM_CH (2) | IRQ lines from the drives, one per channel |
| irq_out | output | 1 | Shared registered interrupt output |
| win_en | output | 1 | Extended register window enable (select bit 5) |
| dma_ch_sel | output | 1 | DMA routing: 0 for channel 0, 1 for channel 1 (select bit 0) |

## Verification
The gate is driven with every combination of enable state and drive IRQ level, one channel at a time and then both together. This separates a gate that ANDs the right pair from one that leaks the other channel's IRQ, and it checks the OR when both channels are pending. Control writes carry 0x00 and 0xFF, which exposes any dependence on the data byte. Reads and writes that collide on one location show which one wins. Writes to status, identity and unmapped offsets, made with IRQs pending, show through irq_out and the select readback whether any of them disturbed state. The IRQ-to-output delay is sampled both one and two edges after a change, so an output path that is too fast or too slow is caught.

// File: rtl/ide_gate_pkg.sv
package ide_gate_pkg;
  typedef logic [7:0] bus_byte_t;

  // bit positions inside the select register
  localparam int unsigned SEL_WIN_BIT = 5;
  localparam int unsigned SEL_DMA_BIT = 0;

  // bit of a status / identity byte carrying the information
  localparam int unsigned INFO_BIT = 0;

  function automatic bus_byte_t bit0_byte(input logic b);
    bus_byte_t r;
    r = '0;
    r[INFO_BIT] = b;
    return r;
  endfunction
endpackage

// File: rtl/ide_gate_decode.sv
module ide_gate_decode #(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned CTRL_BASE = 'h2200,
  parameter int unsigned STAT_BASE = 'h2290,
  parameter int unsigned CH_STRIDE = 'h1000,
  parameter int unsigned ID_BASE   = 'h2280,
  parameter int unsigned ID_STEP   = 4,
  parameter int unsigned ID_BITS   = 4,
  parameter int unsigned SEL_ADDR  = 0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CH-1:0]  ctrl_hit,
  output logic [NUM_CH-1:0]  stat_hit,
  output logic [ID_BITS-1:0] id_hit,
  output logic               sel_hit,
  output logic               any_hit
);
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_BASE + g * CH_STRIDE);
    assign ctrl_hit[g] = (addr == CTRL_A);
    assign stat_hit[g] = (addr == STAT_A);
  end

  for (genvar i = 0; i < ID_BITS; i++) begin : g_id
    localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_BASE + i * ID_STEP);
    assign id_hit[i] = (addr == ID_A);
  end

  assign sel_hit = (addr == SEL_A);
  assign any_hit = sel_hit | (|ctrl_hit) | (|stat_hit) | (|id_hit);
endmodule

// File: rtl/ide_gate_chan.sv
module ide_gate_chan (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic en_set,
  input  logic en_clr,
  output logic en_q,
  output logic lat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      lat_q <= irq_in;
      if (en_clr)
        en_q <= 1'b0;
      else if (en_set)
        en_q <= 1'b1;
    end
  end

  // R1: a write alone opens the gate
  p_wr_enables_r1: assert property (@(posedge clk) disable iff (rst)
    (en_set && !en_clr) |=> en_q);

  // R2 and R10: any read closes the gate, even with a write in the same cycle
  p_rd_disables_r2: assert property (@(posedge clk) disable iff (rst)
    en_clr |=> !en_q);

  // R9: no control access, no change
  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_set && !en_clr) |=> $stable(en_q));
endmodule

// File: rtl/ide_gate_rdmux.sv
module ide_gate_rdmux
  import ide_gate_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ID_BITS   = 4,
  parameter logic [ID_BITS-1:0] CARD_CODE = 4'd3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [NUM_CH-1:0]  stat_hit,
  input  logic [ID_BITS-1:0] id_hit,
  input  logic               sel_hit,
  input  logic               any_hit,
  input  logic [NUM_CH-1:0]  lat,
  input  bus_byte_t          sel_byte,
  output bus_byte_t          rdata
);
  bus_byte_t nxt;

  always_comb begin
    nxt = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (stat_hit[c]) nxt = bit0_byte(lat[c]);
    for (int i = 0; i < ID_BITS; i++)
      if (id_hit[i]) nxt = bit0_byte(CARD_CODE[i]);
    if (sel_hit) nxt = sel_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= nxt;
    else         rdata <= '0;
  end

  // R9: an unmapped read returns zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && !any_hit) |=> (rdata == 8'h00));

  // R3: status reads never set the upper bits
  p_stat_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (rd && (|stat_hit)) |=> (rdata[7:1] == 7'h0));
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
  import ide_gate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned CTRL_BASE = 'h2200,
  parameter int unsigned STAT_BASE = 'h2290,
  parameter int unsigned CH_STRIDE = 'h1000,
  parameter int unsigned ID_BASE   = 'h2280,
  parameter int unsigned ID_STEP   = 4,
  parameter int unsigned ID_BITS   = 4,
  parameter logic [ID_BITS-1:0] CARD_CODE = 4'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] drv_irq,
  output logic              irq_out,
  output logic              win_en,
  output logic              dma_ch_sel
);
  logic [NUM_CH-1:0]  ctrl_hit, stat_hit, en_q, lat_q;
  logic [ID_BITS-1:0] id_hit;
  logic               sel_hit, any_hit;
  bus_byte_t          sel_byte;
  logic               unused_wdata;

  assign unused_wdata = ^{bus_wdata[7:6], bus_wdata[4:1]};

  ide_gate_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CTRL_BASE(CTRL_BASE),
    .STAT_BASE(STAT_BASE), .CH_STRIDE(CH_STRIDE), .ID_BASE(ID_BASE),
    .ID_STEP(ID_STEP), .ID_BITS(ID_BITS), .SEL_ADDR(0)
  ) u_dec (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit),
    .id_hit(id_hit), .sel_hit(sel_hit), .any_hit(any_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    ide_gate_chan u_chan (
      .clk(clk), .rst(rst), .irq_in(drv_irq[g]),
      .en_set(bus_wr & ctrl_hit[g]),
      .en_clr(bus_rd & ctrl_hit[g]),
      .en_q(en_q[g]), .lat_q(lat_q[g])
    );
  end

  // select register: only the window and DMA routing bits are held
  always_ff @(posedge clk) begin
    if (rst) begin
      win_en     <= 1'b0;
      dma_ch_sel <= 1'b0;
    end else if (bus_wr && sel_hit) begin
      win_en     <= bus_wdata[SEL_WIN_BIT];
      dma_ch_sel <= bus_wdata[SEL_DMA_BIT];
    end
  end

  always_comb begin
    sel_byte = '0;
    sel_byte[SEL_WIN_BIT] = win_en;
    sel_byte[SEL_DMA_BIT] = dma_ch_sel;
  end

  ide_gate_rdmux #(
    .NUM_CH(NUM_CH), .ID_BITS(ID_BITS), .CARD_CODE(CARD_CODE)
  ) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .stat_hit(stat_hit),
    .id_hit(id_hit), .sel_hit(sel_hit), .any_hit(any_hit),
    .lat(lat_q), .sel_byte(sel_byte), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(en_q & lat_q);
  end

  // R4: the shared output is only raised with some channel enabled
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|en_q));

  // R7: the select bits only move on a write to offset 0
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel_hit) |=> ($stable(win_en) && $stable(dma_ch_sel)));
endmodule

// File: tb/ide_irq_gate_bench.sv
module ide_irq_gate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  drv_irq;
  logic        irq_out, win_en, dma_ch_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [13:0] C0 = 14'h2200, C1 = 14'h3200;
  localparam logic [13:0] S0 = 14'h2290, S1 = 14'h3290;

  always #4 clk = ~clk;

  ide_irq_gate u_ide_irq_gate (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .irq_out(irq_out), .win_en(win_en),
    .dma_ch_sel(dma_ch_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_irq(input logic [1:0] v);
    @(negedge clk);
    drv_irq = v;
    settle();
  endtask

  task automatic park();
    logic [7:0] d;
    rd(C0, d);
    rd(C1, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    drv_irq = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R8 irq_out after reset with irqs high", {7'b0, irq_out}, 8'h00);
    chk("R8 win_en", {7'b0, win_en}, 8'h00);
    chk("R8 dma_ch_sel", {7'b0, dma_ch_sel}, 8'h00);
    rd(14'h0000, d);
    chk("R8 select readback", d, 8'h00);
  endtask

  task automatic t_enable_any_data();
    set_irq(2'b01);
    wr(C0, 8'h00);
    settle();
    chk("R1 ch0 enable with data 00", {7'b0, irq_out}, 8'h01);
    park();
    settle();
    chk("R1 parked", {7'b0, irq_out}, 8'h00);
    set_irq(2'b10);
    wr(C1, 8'hFF);
    settle();
    chk("R1 ch1 enable with data FF", {7'b0, irq_out}, 8'h01);
    park();
  endtask

  task automatic t_read_disables();
    logic [7:0] d;
    set_irq(2'b11);
    wr(C0, 8'h5A);
    wr(C1, 8'hA5);
    settle();
    chk("R2 both enabled", {7'b0, irq_out}, 8'h01);
    rd(C0, d);
    chk("R2 ctrl read data", d, 8'h00);
    settle();
    chk("R2 ch1 still on", {7'b0, irq_out}, 8'h01);
    rd(C1, d);
    chk("R2 ctrl read data ch1", d, 8'h00);
    settle();
    chk("R2 both off", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    set_irq(2'b01);
    rd(S0, d); chk("R3 status ch0 pending, gate closed", d, 8'h01);
    rd(S1, d); chk("R3 status ch1 idle", d, 8'h00);
    set_irq(2'b10);
    wr(C1, 8'h00);
    rd(S0, d); chk("R3 status ch0 idle", d, 8'h00);
    rd(S1, d); chk("R3 status ch1 pending, gate open", d, 8'h01);
    park();
  endtask

  task automatic t_shared_out();
    set_irq(2'b00);
    wr(C1, 8'h01);
    settle();
    @(negedge clk); drv_irq = 2'b01;
    settle();
    chk("R4 other channel irq does not leak", {7'b0, irq_out}, 8'h00);
    @(negedge clk); drv_irq = 2'b10;
    @(negedge clk);
    chk("R4 one edge after irq, output still low", {7'b0, irq_out}, 8'h00);
    @(negedge clk);
    chk("R4 two edges after irq, output high", {7'b0, irq_out}, 8'h01);
    @(negedge clk); drv_irq = 2'b00;
    @(negedge clk);
    chk("R4 one edge after drop, still high", {7'b0, irq_out}, 8'h01);
    @(negedge clk);
    chk("R4 two edges after drop, low", {7'b0, irq_out}, 8'h00);
    park();
  endtask

  task automatic t_exclusive();
    logic [7:0] d;
    wr(C0, 8'h00); rd(C1, d);
    set_irq(2'b10);
    chk("R5 ch0 active, ch1 blocked", {7'b0, irq_out}, 8'h00);
    set_irq(2'b01);
    chk("R5 ch0 active, ch0 passes", {7'b0, irq_out}, 8'h01);
    wr(C1, 8'h00); rd(C0, d);
    settle();
    chk("R5 ch1 active, ch0 blocked", {7'b0, irq_out}, 8'h00);
    set_irq(2'b10);
    chk("R5 ch1 active, ch1 passes", {7'b0, irq_out}, 8'h01);
    park();
  endtask

  task automatic t_ident();
    logic [7:0] d;
    logic [3:0] code = 4'd3;
    for (int i = 0; i < 4; i++) begin
      rd(14'h2280 + 14'(4 * i), d);
      chk($sformatf("R6 identity bit %0d", i), d, {7'b0, code[i]});
    end
  endtask

  task automatic t_select();
    logic [7:0] d;
    wr(14'h0000, 8'hFF);
    chk("R7 window bit", {7'b0, win_en}, 8'h01);
    chk("R7 dma bit", {7'b0, dma_ch_sel}, 8'h01);
    rd(14'h0000, d);
    chk("R7 readback masked", d, 8'h21);
    wr(14'h0000, 8'h20);
    rd(14'h0000, d);
    chk("R7 window only", d, 8'h20);
    chk("R7 dma to ch0", {7'b0, dma_ch_sel}, 8'h00);
    wr(14'h0000, 8'h00);
    chk("R7 cleared", {6'b0, win_en, dma_ch_sel}, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    set_irq(2'b11);
    wr(S0, 8'hFF); wr(S1, 8'hFF); wr(14'h2280, 8'hFF);
    wr(14'h2201, 8'hFF); wr(14'h1234, 8'h21);
    settle();
    chk("R9 stray writes enable nothing", {7'b0, irq_out}, 8'h00);
    rd(14'h0000, d);
    chk("R9 stray writes leave select", d, 8'h00);
    rd(14'h2204, d); chk("R9 unmapped read 2204", d, 8'h00);
    rd(14'h3FFF, d); chk("R9 unmapped read 3FFF", d, 8'h00);
  endtask

  task automatic t_collision();
    set_irq(2'b11);
    @(negedge clk);
    bus_addr = C0; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    settle();
    chk("R10 read wins over write", {7'b0, irq_out}, 8'h00);
    wr(C0, 8'h00);
    settle();
    chk("R10 enabled before collision", {7'b0, irq_out}, 8'h01);
    @(negedge clk);
    bus_addr = C0; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    settle();
    chk("R10 collision disables", {7'b0, irq_out}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_enable_any_data();
    t_read_disables();
    t_status();
    t_shared_out();
    t_exclusive();
    t_ident();
    t_select();
    t_unmapped();
    t_collision();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule